// File: doc/BRIEF.md
# Serial NAND Bring-up Sequencer

This block is a hardware master that brings an attached serial NAND flash into a usable state after power-on, with no software involvement. A pulse on `start` launches a fixed series of single-lane SPI command frames. First comes a device reset. Status polling follows it until the device reports ready. The block then fetches the identification bytes and writes the block-protection feature register to clear every lock bit. A `done` pulse ends the series, and `err_code` tells whether it ran to completion.

When the series is launched, the block also compares the controller capability vector with the device mode vector. From the cheapest-to-reach fastest mode they share, it picks the cache-read opcode and the program-load opcode. The engine that later moves page data uses these opcodes. The SPI clock is the system clock divided by `CLK_DIV`. The ready timeout is `TIMEOUT_CYCLES` system clocks, counted from the end of the reset frame.

Top module: `snand_bringup`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `done` and `err_code` are 0, `rd_opcode` is 0Bh, `wr_opcode` is 02h, and `id_bytes` and `status_byte` are 0.
- R2: Each sequence begins with a one-byte frame carrying FFh, with no address and no data. Status polling follows it directly.
- R3: A status poll is a three-byte frame: 0Fh, then C0h, then one byte clocked in on `spi_miso`. Polls repeat while bit 0 of the returned byte is 1. `status_byte` holds the byte from the most recent poll.
- R4: A busy poll may end at or after `TIMEOUT_CYCLES` clocks from the end of the reset frame. In that case exactly one further poll is made. If that poll is also busy, the block pulses `done` with `err_code` = 1 and sends no further frames.
- R5: If the extra poll made after the timeout returns ready, the sequence continues normally and ends with `err_code` = 0.
- R6: The identification frame is 9Fh followed by four bytes clocked in while MOSI sends 00h. `id_bytes[31:24]` holds the first byte received and `id_bytes[7:0]` the last.
- R7: After identification the block sends the frame 1Fh, A0h, 00h. It then pulses `done` with `err_code` = 0.
- R8: `rd_opcode` is chosen from the AND of `ctrl_caps` and `dev_modes`, taking the first shared mode in this order: bit 3 (quad I/O) gives EBh, bit 2 (x4 output) gives 6Bh, bit 1 (dual I/O) gives BBh, bit 0 (x2 output) gives 3Bh. If none is shared, the result is 0Bh.
- R9: `wr_opcode` is 32h when bit 4 (x4 program load) is set in both vectors, and 02h otherwise. Both opcodes are captured at launch and held for the whole sequence.
- R10: SPI runs in mode 0 with MSB first. SCLK is low whenever CS_n is high. MOSI changes only while SCLK is low. CS_n stays high for at least `CLK_DIV` clocks between frames.
- R11: `start` has no effect while a sequence is running. A `start` after `done` runs the whole sequence again, starting from the reset frame.
- R12: `done` is a single-cycle pulse, and each sequence produces exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the bring-up sequence |
| ctrl_caps | input | 5 | Controller transfer capabilities (bit map as in R8/R9) |
| dev_modes | input | 5 | Device transfer modes (same bit map) |
| done | output | 1 | One-cycle pulse at sequence end |
| err_code | output | 2 | 0 = success, 1 = device never became ready |
| status_byte | output | 8 | Last status byte read |
| id_bytes | output | 32 | Raw identification bytes, first byte in the top |
| rd_opcode | output | 8 | Selected cache-read opcode |
| wr_opcode | output | 8 | Selected program-load opcode |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to device |
| spi_miso | input | 1 | SPI data from device |

## Verification
The bench targets the timeout edge. It builds a device that becomes ready exactly on the poll made after the limit, so a design that skips the final re-check reports a false timeout. A second device never becomes ready, so a design that keeps polling, or that goes on to identification and unlock, is caught. Capability pairs with the quad or x4 mode on one side only exercise the priority chain; a design that ORs the vectors, or reverses the priority, returns the wrong opcode. A `start` pulse in the middle of polling catches a sequencer that restarts, because the device model would then see a second reset frame.

// File: rtl/snand_bringup.sv
module snand_bringup #(
  parameter int CLK_DIV        = 4,
  parameter int TIMEOUT_CYCLES = 80_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [4:0]  ctrl_caps,
  input  logic [4:0]  dev_modes,
  output logic        done,
  output logic [1:0]  err_code,
  output logic [7:0]  status_byte,
  output logic [31:0] id_bytes,
  output logic [7:0]  rd_opcode,
  output logic [7:0]  wr_opcode,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF  = CLK_DIV / 2;
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_RISE = DIV_W'(HALF - 1);
  localparam logic [TMR_W-1:0] TMR_LIM  = TMR_W'(TIMEOUT_CYCLES);

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} state_t;
  typedef enum logic [1:0] {SP_RST, SP_POLL, SP_ID, SP_UNLOCK} step_t;

  state_t           state;
  step_t            step;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [2:0]       byte_idx;
  logic [7:0]       txsh;
  logic [7:0]       rxsh;
  logic [TMR_W-1:0] tmr;
  logic             final_chk;

  function automatic logic [7:0] tx_byte(step_t s, logic [2:0] i);
    case (s)
      SP_RST:  return 8'hFF;
      SP_POLL: return (i == 3'd0) ? 8'h0F : (i == 3'd1) ? 8'hC0 : 8'h00;
      SP_ID:   return (i == 3'd0) ? 8'h9F : 8'h00;
      default: return (i == 3'd0) ? 8'h1F : (i == 3'd1) ? 8'hA0 : 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] last_idx(step_t s);
    case (s)
      SP_RST:  return 3'd0;
      SP_ID:   return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  logic [4:0] shared;
  logic [7:0] rd_pick;
  logic [7:0] wr_pick;
  assign shared  = ctrl_caps & dev_modes;
  assign wr_pick = shared[4] ? 8'h32 : 8'h02;

  always_comb begin
    if (shared[3])      rd_pick = 8'hEB;
    else if (shared[2]) rd_pick = 8'h6B;
    else if (shared[1]) rd_pick = 8'hBB;
    else if (shared[0]) rd_pick = 8'h3B;
    else                rd_pick = 8'h0B;
  end

  logic  gap_end, tmr_out;
  logic  launch, fin_ok, fin_err, arm_final;
  step_t nstep;
  assign gap_end = (state == ST_GAP) && (div_cnt == DIV_LAST);
  assign tmr_out = (tmr == TMR_LIM);

  always_comb begin
    launch    = 1'b0;
    fin_ok    = 1'b0;
    fin_err   = 1'b0;
    arm_final = 1'b0;
    nstep     = step;
    if (state == ST_IDLE && start) begin
      launch = 1'b1;
      nstep  = SP_RST;
    end else if (gap_end) begin
      case (step)
        SP_RST: begin launch = 1'b1; nstep = SP_POLL; end
        SP_POLL:
          if (!status_byte[0]) begin
            launch = 1'b1; nstep = SP_ID;
          end else if (final_chk) begin
            fin_err = 1'b1;
          end else begin
            launch = 1'b1; nstep = SP_POLL; arm_final = tmr_out;
          end
        SP_ID:   begin launch = 1'b1; nstep = SP_UNLOCK; end
        default: fin_ok = 1'b1;
      endcase
    end
  end

  assign spi_mosi = !spi_cs_n && txsh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      step        <= SP_RST;
      div_cnt     <= '0;
      bit_cnt     <= '0;
      byte_idx    <= '0;
      txsh        <= '0;
      rxsh        <= '0;
      tmr         <= '0;
      final_chk   <= 1'b0;
      done        <= 1'b0;
      err_code    <= 2'd0;
      status_byte <= '0;
      id_bytes    <= '0;
      rd_opcode   <= 8'h0B;
      wr_opcode   <= 8'h02;
      spi_sclk    <= 1'b0;
      spi_cs_n    <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!tmr_out) tmr <= tmr + 1'b1;
      if (state == ST_IDLE && start) begin
        rd_opcode <= rd_pick;
        wr_opcode <= wr_pick;
        err_code  <= 2'd0;
        final_chk <= 1'b0;
      end
      if (arm_final) final_chk <= 1'b1;
      if (launch) begin
        state    <= ST_FRAME;
        step     <= nstep;
        spi_cs_n <= 1'b0;
        div_cnt  <= '0;
        bit_cnt  <= '0;
        byte_idx <= '0;
        txsh     <= tx_byte(nstep, 3'd0);
      end else if (fin_ok || fin_err) begin
        state    <= ST_IDLE;
        done     <= 1'b1;
        err_code <= fin_err ? 2'd1 : 2'd0;
      end else if (state == ST_GAP) begin
        div_cnt <= div_cnt + 1'b1;
      end else if (state == ST_FRAME) begin
        if (div_cnt == DIV_RISE) begin
          spi_sclk <= 1'b1;
          rxsh     <= {rxsh[6:0], spi_miso};
        end
        if (div_cnt == DIV_LAST) begin
          div_cnt  <= '0;
          spi_sclk <= 1'b0;
          if (bit_cnt == 3'd7) begin
            bit_cnt <= '0;
            if (step == SP_POLL && byte_idx == 3'd2) status_byte <= rxsh;
            if (step == SP_ID && byte_idx != 3'd0)  id_bytes    <= {id_bytes[23:0], rxsh};
            if (byte_idx == last_idx(step)) begin
              state    <= ST_GAP;
              spi_cs_n <= 1'b1;
              if (step == SP_RST) tmr <= '0;
            end else begin
              byte_idx <= byte_idx + 3'd1;
              txsh     <= tx_byte(step, byte_idx + 3'd1);
            end
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            txsh    <= {txsh[6:0], 1'b0};
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R10
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  opcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(rd_opcode) && $stable(wr_opcode)));

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 2'd1) |-> spi_cs_n);

endmodule

// File: tb/snand_bringup_test.sv
`timescale 1ns/1ps
module snand_bringup_test;
  localparam int DIV = 4;
  localparam int TO  = 1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0] ctrl_caps = '0, dev_modes = '0;
  logic done, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  logic [1:0] err_code;
  logic [7:0] status_byte, rd_opcode, wr_opcode;
  logic [31:0] id_bytes;

  always #2.5 clk = ~clk;

  snand_bringup #(.CLK_DIV(DIV), .TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_caps(ctrl_caps), .dev_modes(dev_modes),
    .done(done), .err_code(err_code), .status_byte(status_byte), .id_bytes(id_bytes),
    .rd_opcode(rd_opcode), .wr_opcode(wr_opcode), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [4:0] b);
    if (b[3]) return 8'hEB;
    if (b[2]) return 8'h6B;
    if (b[1]) return 8'hBB;
    if (b[0]) return 8'h3B;
    return 8'h0B;
  endfunction

  logic [7:0] fb[$];
  logic [7:0] cur;
  logic [31:0] idv;
  int nbits, since_rst, start_cnt, poll_idx, ready_after, hi_run;
  int phase = 6;
  bit rescue, cur_ready, prev_cs = 1, prev_sclk = 0;

  function automatic int first_b();
    return (fb.size() > 0) ? int'(fb[0]) : -1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    since_rst++;
    if (rst_n) begin
      chk(!(spi_cs_n && spi_sclk), "R10", "sclk high while deselected", spi_sclk, 0);
      if (prev_cs && !spi_cs_n) begin
        chk(hi_run >= DIV, "R10", "deselect gap", hi_run, DIV);
        nbits = 0; fb.delete(); cur = '0; start_cnt = since_rst;
        cur_ready = (poll_idx >= ready_after) || (rescue && start_cnt >= TO + 1);
      end
      if (!spi_cs_n && spi_sclk && !prev_sclk) begin
        cur = {cur[6:0], spi_mosi};
        nbits++;
        if (nbits % 8 == 0) fb.push_back(cur);
      end
      if (!prev_cs && spi_cs_n) begin
        case (phase)
          0: begin
            chk(fb.size() == 1 && fb[0] == 8'hFF, "R2", "reset frame", first_b(), 8'hFF);
            since_rst = 0; poll_idx = 0; phase = 1;
          end
          1: begin
            chk(fb.size() == 3 && fb[0] == 8'h0F && fb[1] == 8'hC0, "R3", "poll frame",
                first_b(), 8'h0F);
            if (cur_ready) phase = 2;
            else if (start_cnt >= TO + 1) phase = 5;
            poll_idx++;
          end
          2: begin
            chk(fb.size() == 5 && fb[0] == 8'h9F && fb[1] == 0 && fb[4] == 0, "R6",
                "id frame", first_b(), 8'h9F);
            phase = 3;
          end
          3: begin
            chk(fb.size() == 3 && fb[0] == 8'h1F && fb[1] == 8'hA0 && fb[2] == 8'h00, "R7",
                "unlock frame", first_b(), 8'h1F);
            phase = 4;
          end
          default: chk(0, "R11", "unexpected frame", first_b(), -1);
        endcase
      end
      if (done) begin
        if (phase == 4) begin
          chk(err_code == 0, "R7", "error code ok", err_code, 0);
          chk(id_bytes == idv, "R6", "id bytes", id_bytes, idv);
          chk(status_byte == 8'h00, "R3", "last status", status_byte, 0);
          chk(rd_opcode == exp_rd(ctrl_caps & dev_modes), "R8", "read opcode", rd_opcode,
              exp_rd(ctrl_caps & dev_modes));
          chk(wr_opcode == (((ctrl_caps & dev_modes) & 5'h10) != 0 ? 8'h32 : 8'h02), "R9",
              "write opcode", wr_opcode, ((ctrl_caps & dev_modes) & 5'h10) != 0 ? 8'h32 : 8'h02);
          if (rescue) chk(poll_idx == 11, "R5", "polls before rescue", poll_idx, 11);
        end else if (phase == 5) begin
          chk(err_code == 1, "R4", "timeout error", err_code, 1);
          chk(status_byte == 8'h01, "R4", "busy status kept", status_byte, 1);
          chk(poll_idx == 11, "R4", "poll count incl. final", poll_idx, 11);
        end else chk(0, "R12", "unexpected done", phase, 4);
        phase = 6;
      end
      spi_miso = 1'b0;
      if (!spi_cs_n && fb.size() >= 1) begin
        if (fb[0] == 8'h0F && nbits == 23) spi_miso = !cur_ready;
        else if (fb[0] == 8'h9F && nbits >= 8 && nbits < 40) spi_miso = idv[39 - nbits];
      end
    end
    hi_run = spi_cs_n ? hi_run + 1 : 0;
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run(input logic [4:0] cc, input logic [4:0] dm, input int rdy,
                     input bit resc, input logic [31:0] idval, input bit mid_start);
    ctrl_caps = cc; dev_modes = dm; ready_after = rdy; rescue = resc; idv = idval;
    poll_idx = 0; phase = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (phase != 6) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R11", "idle after done", spi_cs_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(spi_cs_n == 1 && spi_sclk == 0 && done == 0, "R1", "pins at reset",
        {spi_cs_n, spi_sclk, done}, 3'b100);
    chk(err_code == 0 && id_bytes == 0 && status_byte == 0, "R1", "outputs at reset",
        id_bytes, 0);
    chk(rd_opcode == 8'h0B && wr_opcode == 8'h02, "R1", "opcodes at reset",
        {rd_opcode, wr_opcode}, 16'h0B02);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run(5'h1F, 5'h1F, 2, 0, 32'hA1B2C3D4, 0);
    run(5'h07, 5'h16, 0, 0, 32'h2C241500, 0);
    run(5'h0B, 5'h13, 1, 0, 32'hEF0F0F80, 0);
    run(5'h11, 5'h01, 0, 0, 32'h01020304, 0);
    run(5'h08, 5'h04, 0, 0, 32'h55AA33CC, 0);
    // R11: start pulse during polling has no effect
    run(5'h1F, 5'h0C, 3, 0, 32'h9876FEDC, 1);
    // R5: ready only on the post-timeout re-check
    run(5'h1F, 5'h1F, 1000000, 1, 32'hC8D9E0F1, 0);
    // R4: device never becomes ready
    run(5'h1F, 5'h1F, 1000000, 0, 32'h11111111, 0);
    // R11: restart after an error
    run(5'h10, 5'h10, 0, 0, 32'hDEADBEEF, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule